// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into a one-cycle strobe that marks the start of every serial bit. The bit period is set by a 14-bit integer divisor field and a 3-bit eighths code. In the normal range the strobe spacing is n + k/8 base periods, where one base period is 16 system clocks (3 MHz from 48 MHz). The eighths part is produced by dithering. Each bit period is either n or n + 1 base periods long. An accumulator spreads the longer periods evenly, so that any eight periods in a row add up to 8n + k base periods.

Two integer values are decoded as fixed fast rates instead of divisors. A value of 0 gives a strobe every 16 clocks (3 Mbaud). A value of 1 gives a strobe every 24 clocks (2 Mbaud). In both fast rates the eighths code has no effect. The configuration inputs may change at any time. The block copies them only at a strobe boundary, so the bit in progress always completes with the settings it started with. The first copy is taken on the first clock after reset. Integer values 2 to 16383 are usable divisors.

Top module: `baud_prescaler`

## Requirements
- R1: While reset is asserted `baud_tick` is 0. After reset is released, the first tick appears exactly one full bit period after the first clock edge, computed from the configuration present at that edge.
- R2: `baud_tick` is never high for two consecutive clocks.
- R3: With `div_int` = 0 the tick spacing is 16 clocks for every value of `div_frac`, including when `div_frac` changes while the block runs.
- R4: With `div_int` = 1 the tick spacing is 24 clocks for every value of `div_frac`.
- R5: With `div_int` = n in 2..16383 and `div_frac` = 0, every tick spacing is 16·n clocks.
- R6: With `div_int` = n ≥ 2 and `div_frac` = k, the i-th period after a fresh load is 16·(n + e) clocks. Here e = floor(i·k/8) − floor((i−1)·k/8), with i counted from 1.
- R7: After a fresh load in the dithered range with an unchanged configuration, the first eight periods together last 128·n + 16·k clocks.
- R8: A configuration change made in the middle of a period does not alter that period. It takes effect from the period that starts at the next tick.
- R9: A reload whose values differ from the active ones restarts the dither sequence (i = 1 again). Rewriting identical values does not restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (16 × base rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | 14 | Integer divisor; 0 and 1 select the fixed fast rates |
| div_frac | input | 3 | Eighths to add to the divisor, k in 0..7 |
| baud_tick | output | 1 | One-clock strobe at the start of each bit |

## Verification
A corrupted dither accumulator shows up as one period that is 16 clocks too long or too short. It appears at the next tick and breaks the eight-period sum at most eight ticks later. A wrong mode decode or a missed reload boundary changes the spacing of the very next tick. For that reason every tick spacing is measured and compared against a bench-side formula. Random configuration writes land at arbitrary points inside periods, so reloads that happen too early are caught within one bit.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    MODE_FAST3M = 2'd0,
    MODE_FAST2M = 2'd1,
    MODE_DITHER = 2'd2
  } rate_mode_e;

  // Integer field to rate mode.
  function automatic rate_mode_e decode_mode(input int unsigned n);
    if (n == 0)      return MODE_FAST3M;
    else if (n == 1) return MODE_FAST2M;
    else             return MODE_DITHER;
  endfunction

endpackage

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold
  import baud_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              armed,
  output logic              load_evt,
  output logic              fresh,
  output logic [INT_W-1:0]  act_int,
  output rate_mode_e        act_mode
);

  logic              armed_q;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  rate_mode_e        mode_q;

  // Reload on the first clock after reset and at every tick boundary.
  assign load_evt = !armed_q || tick;
  assign fresh    = !armed_q || (div_int != int_q) || (div_frac != frac_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      int_q   <= '0;
      frac_q  <= '0;
      mode_q  <= MODE_FAST3M;
    end else if (load_evt) begin
      armed_q <= 1'b1;
      int_q   <= div_int;
      frac_q  <= div_frac;
      mode_q  <= decode_mode(int'(div_int));
    end
  end

  assign armed    = armed_q;
  assign act_int  = int_q;
  assign act_mode = mode_q;

endmodule

// File: rtl/baud_dither.sv
module baud_dither
  import baud_pkg::*;
#(
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              fresh,
  input  rate_mode_e        mode_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              extra
);

  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [FRAC_W-1:0] k_eff;
  logic [FRAC_W:0]   sum;

  // The fraction code only counts in the dithered range.
  assign k_eff = (mode_in == MODE_DITHER) ? frac_in : '0;
  assign sum   = {1'b0, (fresh ? {FRAC_W{1'b0}} : acc_q)} + {1'b0, k_eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (load_evt) begin
      acc_q   <= sum[FRAC_W-1:0];
      extra_q <= sum[FRAC_W];
    end
  end

  assign extra = extra_q;

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
  import baud_pkg::*;
#(
  parameter int INT_W       = 14,
  parameter int BASE_DIV    = 16,
  parameter int FAST2M_CLKS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             load_evt,
  input  rate_mode_e       act_mode,
  input  logic [INT_W-1:0] act_int,
  input  logic             extra,
  output logic             base_stb,
  output logic             tick
);

  localparam int SUB_MAX = (FAST2M_CLKS > BASE_DIV) ? FAST2M_CLKS : BASE_DIV;
  localparam int SUB_W   = $clog2(SUB_MAX);
  localparam int UNIT_W  = INT_W + 1;

  logic [SUB_W-1:0]  sub_q;
  logic [SUB_W-1:0]  sub_lim;
  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] unit_tgt;

  assign sub_lim  = (act_mode == MODE_FAST2M) ? SUB_W'(FAST2M_CLKS - 1)
                                              : SUB_W'(BASE_DIV - 1);
  assign unit_tgt = (act_mode == MODE_DITHER) ? ({1'b0, act_int} + UNIT_W'(extra))
                                              : UNIT_W'(1);

  assign base_stb = armed && (sub_q == sub_lim);
  assign tick     = base_stb && ((unit_q + UNIT_W'(1)) == unit_tgt);

  // First stage: clocks within one base period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sub_q <= '0;
    else if (load_evt || sub_q == sub_lim) sub_q <= '0;
    else                               sub_q <= sub_q + SUB_W'(1);
  end

  // Second stage: base periods within one bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        unit_q <= '0;
    else if (load_evt) unit_q <= '0;
    else if (base_stb) unit_q <= unit_q + UNIT_W'(1);
  end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int INT_W       = 14,
  parameter int FRAC_W      = 3,
  parameter int BASE_DIV    = 16,
  parameter int FAST2M_CLKS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              baud_tick
);

  logic             armed;
  logic             load_evt;
  logic             fresh;
  logic [INT_W-1:0] act_int;
  rate_mode_e       act_mode;
  rate_mode_e       mode_in;
  logic             extra;
  logic             base_stb;
  logic             tick;

  assign mode_in = decode_mode(int'(div_int));

  baud_cfg_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .div_int(div_int), .div_frac(div_frac),
    .armed(armed), .load_evt(load_evt), .fresh(fresh),
    .act_int(act_int), .act_mode(act_mode)
  );

  baud_dither #(.FRAC_W(FRAC_W)) u_dith (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .fresh(fresh),
    .mode_in(mode_in), .frac_in(div_frac), .extra(extra)
  );

  baud_period_cnt #(.INT_W(INT_W), .BASE_DIV(BASE_DIV), .FAST2M_CLKS(FAST2M_CLKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .armed(armed), .load_evt(load_evt),
    .act_mode(act_mode), .act_int(act_int), .extra(extra),
    .base_stb(base_stb), .tick(tick)
  );

  assign baud_tick = tick;

endmodule

// File: rtl/baud_prescaler_chk.sv
module baud_prescaler_chk
  import baud_pkg::*;
#(
  parameter int INT_W       = 14,
  parameter int BASE_DIV    = 16,
  parameter int FAST2M_CLKS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             load_evt,
  input rate_mode_e       act_mode,
  input logic [INT_W-1:0] act_int
);

  // Cycles since the last reload, counted independently of the design.
  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (load_evt) gap_q <= '0;
    else               gap_q <= gap_q + 32'd1;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !baud_tick);

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  a_r3_fast3m_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && act_mode == MODE_FAST3M) |-> gap_q == 32'(BASE_DIV - 1));

  a_r4_fast2m_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && act_mode == MODE_FAST2M) |-> gap_q == 32'(FAST2M_CLKS - 1));

  a_r6_base_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && act_mode == MODE_DITHER) |-> ((gap_q + 32'd1) % 32'(BASE_DIV)) == 32'd0);

  a_r6_span: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && act_mode == MODE_DITHER) |->
      ((gap_q + 32'd1) >= 32'(BASE_DIV) * 32'(act_int) &&
       (gap_q + 32'd1) <= 32'(BASE_DIV) * (32'(act_int) + 32'd1)));

  a_r8_hold_mid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_int) && $stable(act_mode));

endmodule

bind baud_prescaler baud_prescaler_chk #(
  .INT_W(INT_W), .BASE_DIV(BASE_DIV), .FAST2M_CLKS(FAST2M_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load_evt(load_evt),
  .act_mode(act_mode), .act_int(act_int)
);

// File: tb/sim_baud_prescaler.sv
module sim_baud_prescaler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] div_int = 14'd0;
  logic [2:0]  div_frac = 3'd0;
  logic        baud_tick;

  always #4 clk = ~clk;

  baud_prescaler u0 (.clk(clk), .rst_n(rst_n), .div_int(div_int),
                     .div_frac(div_frac), .baud_tick(baud_tick));

  int n_tests = 0, n_fail = 0;
  int cnt = 0, exp_clks = 0, idx = 0, sum8 = 0, ticks = 0;
  int ld_n = -1, ld_k = -1;
  bit pending_plan = 0, prev_tick = 0, mid_chg = 0, rewrite = 0;
  string cur_tag = "R1";

  // Spacing in clocks for period number i (1-based) after a fresh load.
  function automatic int period_of(int n, int k, int i);
    if (n == 0) return 16;
    if (n == 1) return 24;
    return 16 * (n + ((i * k) / 8 - ((i - 1) * k) / 8));
  endfunction

  task automatic check(string tag, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic plan_next();
    int n = int'(div_int), k = int'(div_frac);
    if (n != ld_n || k != ld_k) begin idx = 0; sum8 = 0; end
    ld_n = n; ld_k = k;
    idx++;
    exp_clks = period_of(n, k, idx);
    if (n == 0) cur_tag = "R3";
    else if (n == 1) cur_tag = "R4";
    else if (mid_chg) cur_tag = "R8";
    else if (rewrite) cur_tag = "R9";
    else if (k == 0) cur_tag = "R5";
    else cur_tag = "R6";
    mid_chg = 0;
    pending_plan = 0;
  endtask

  task automatic step();
    if (pending_plan) plan_next();
    @(negedge clk);
    cnt++;
    if (baud_tick) begin
      check("R2", int'(prev_tick), 0);
      check(cur_tag, cnt, exp_clks);
      if (ld_n >= 2 && idx <= 8) begin
        sum8 += cnt;
        if (idx == 8) check("R7", sum8, 128 * ld_n + 16 * ld_k);
      end
      cnt = 0; ticks++; pending_plan = 1;
    end else if (cnt > exp_clks + 2) begin
      check({cur_tag, " late"}, cnt, exp_clks);
      cnt = 0; pending_plan = 1;
    end
    if (cnt > 40000) begin
      check("watchdog", cnt, 0);
      finish_run();
    end
    prev_tick = baud_tick;
  endtask

  task automatic set_cfg(int n, int k);
    if (n == ld_n && k == ld_k) rewrite = 1;
    else if (!pending_plan) mid_chg = 1;
    div_int = 14'(n); div_frac = 3'(k);
  endtask

  task automatic run_ticks(int count);
    int target = ticks + count;
    while (ticks < target) step();
  endtask

  initial begin
    process::self().srandom(32'd1234);
    div_int = 14'd3; div_frac = 3'd0;
    // R1: quiet while in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", int'(baud_tick), 0);
    end
    rst_n = 1'b1; cnt = 0; pending_plan = 1;
    run_ticks(3);                         // R1 first tick, R5 n=3
    set_cfg(0, 5);  run_ticks(4);         // R3 fast 3M, fraction ignored
    for (int i = 0; i < 7; i++) step();
    set_cfg(0, 2);  run_ticks(4);         // R3 fraction change mid-run
    set_cfg(1, 7);  run_ticks(4);         // R4 fast 2M
    set_cfg(2, 0);  run_ticks(4);         // R5 minimum divisor
    set_cfg(2, 7);  run_ticks(10);        // R6, R7
    set_cfg(5, 3);  run_ticks(10);        // R6, R7
    set_cfg(4, 4);  run_ticks(10);        // R6, R7
    // R9: identical rewrite keeps the sequence; a real change restarts it
    set_cfg(3, 3);  run_ticks(3);
    for (int i = 0; i < 20; i++) step();
    set_cfg(3, 3);  run_ticks(6);
    rewrite = 0;
    set_cfg(3, 4);  run_ticks(2);
    set_cfg(3, 3);  run_ticks(9);
    // R8: random changes at random points in the period
    while (ticks < 320) begin
      step();
      if ($urandom_range(0, 119) == 0)
        set_cfg($urandom_range(0, 12), $urandom_range(0, 7));
    end
    finish_run();
  end

endmodule